// File: doc/BRIEF.md
# Packet-Engine Integer ALU with Persistent Condition Codes

This block is the arithmetic and bit-manipulation stage of a small packet-processing engine. Each accepted operation takes an opcode, two operands A and B, a per-byte lane mask, a rotate amount and a condition-code update enable. It produces one registered result and updates a persistent set of four condition flags: negative, zero, signed overflow and carry. The carry flag survives between operations. A wide sum can therefore be built word by word: a plain add on the low words is followed by an add-with-carry on the high words.

Operations are offered on a valid/ready input and results leave on a valid/ready output that is one entry deep. An input is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). The flags change on the same edge that takes the operation, so the next operation sees the updated carry without a bubble. While `out_valid` is high and `out_ready` is low, the result, the no-bit indication and the flags hold their values and no new operation is taken.

The single-operand operations all work on B: move, find-first-set, population count and the rotate-and-merge field load. The field load rotates B left and keeps the bytes whose lane-mask bit is set. It clears all other bytes and leaves every flag untouched, so it can be placed between a compare and the flag test that uses it.

Top module: `pkt_alu`

## Requirements
- R1: After reset `out_valid` is 0, `out_data` is 0, `out_nobit` is 0, the flags `cc_o` are 0 and `in_ready` is 1. The flag bits of `cc_o` are N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R2: Opcode 0 (move) returns B. With updating enabled it sets N to result bit 31 and Z to (result == 0), and it clears V and C.
- R3: Opcode 1 (add) returns A+B modulo 2^32. It sets C to the carry out of bit 31 and V to two's-complement overflow, with N and Z taken from the result.
- R4: Opcode 2 (add with carry) returns A+B+C, where C is the stored carry flag. Its flags are set as for R3, so an add on the low words followed by opcode 2 on the high words gives a 64-bit sum.
- R5: Opcode 3 (byte add) returns A + (B & 0xFF), with flags set as for R3.
- R6: Opcode 4 (subtract) returns A-B. C is set when no borrow occurs (A >= B unsigned), V on two's-complement overflow, and N and Z come from the result.
- R7: Opcodes 5, 6, 7 and 8 return A AND B, A AND NOT B, A OR B and A XOR B. N and Z come from the result, and V and C are cleared.
- R8: Opcode 9 (field load) rotates B left by `in_rot` bits. For each byte lane i whose `in_bmask[i]` is set, result byte i is taken from the rotated value, and every other result byte is 0. The flags are unchanged even when `in_setcc` is 1.
- R9: Opcode 10 (find-first-set) returns the index of the lowest set bit of B. For B = 0 it returns 0 and raises `out_nobit`. `out_nobit` is 0 for every other case and every other opcode. Flags are set as for R7.
- R10: Opcode 11 (population count) returns the number of set bits of B, zero-extended to 32 bits. Flags are set as for R7.
- R11: With `in_setcc` at 0 an accepted operation leaves the flags unchanged. Opcodes 12 to 15 return 0 and never change the flags.
- R12: `in_ready` equals `!out_valid || out_ready`. While the output is stalled, `out_data` and `cc_o` hold their values and an offered operation is not taken until the stall ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block takes the offered operation this cycle |
| in_op | input | 4 | Opcode (see requirements) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_bmask | input | 4 | Byte lane enables for the field load |
| in_rot | input | 5 | Left rotate amount for the field load |
| in_setcc | input | 1 | Allow the operation to update the flags |
| out_valid | output | 1 | A result is held on the output |
| out_ready | input | 1 | Downstream takes the held result |
| out_data | output | 32 | Registered result |
| out_nobit | output | 1 | Find-first-set was given a zero operand |
| cc_o | output | 4 | Flags {N, Z, V, C} |

## Verification
Every result, the no-bit indication and the flag update appear one clock after the rising edge that takes the operation. The bench drives on falling edges and reads the outputs on the falling edge that follows the taking edge. A flag-preserving or flag-disabled operation is checked by comparing `cc_o` on that same falling edge with the value before the operation. For the stall case, the bench offers a second operation while `out_ready` is low and reads `in_ready`, `out_data` and `cc_o` on each falling edge of the stall. It checks the second result one cycle after `out_ready` returns.

// File: rtl/pkt_alu_pkg.sv
package pkt_alu_pkg;

  typedef enum logic [3:0] {
    OP_MOVB = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_ADD8 = 4'd3,
    OP_SUB  = 4'd4,
    OP_AND  = 4'd5,
    OP_ANDN = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_FLD  = 4'd9,
    OP_FFS  = 4'd10,
    OP_POPC = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/pkt_alu_arith.sv
module pkt_alu_arith #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic [W-1:0] logic_res
);
  import pkt_alu_pkg::*;

  logic [W-1:0] opnd_b;
  logic         cin_eff;

  // Operand B conditioning: byte add masks, subtract inverts and injects one
  always_comb begin
    opnd_b  = b;
    cin_eff = 1'b0;
    case (op)
      OP_ADDC: cin_eff = cin;
      OP_ADD8: opnd_b  = {{(W-8){1'b0}}, b[7:0]};
      OP_SUB: begin
        opnd_b  = ~b;
        cin_eff = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    {cout, sum} = {1'b0, a} + {1'b0, opnd_b} + {{W{1'b0}}, cin_eff};
    ovf = (a[W-1] == opnd_b[W-1]) && (sum[W-1] != a[W-1]);
  end

  always_comb begin
    case (op)
      OP_AND:  logic_res = a & b;
      OP_ANDN: logic_res = a & ~b;
      OP_OR:   logic_res = a | b;
      OP_XOR:  logic_res = a ^ b;
      default: logic_res = '0;
    endcase
  end

endmodule

// File: rtl/pkt_alu_bits.sv
module pkt_alu_bits #(
  parameter int W  = 32,
  parameter int NB = W / 8,
  parameter int RW = $clog2(W)
) (
  input  logic [W-1:0]  b,
  input  logic [NB-1:0] bmask,
  input  logic [RW-1:0] rot,
  output logic [W-1:0]  fld_res,
  output logic [W-1:0]  ffs_res,
  output logic          ffs_none,
  output logic [W-1:0]  pop_res
);
  localparam int CNT_W = $clog2(W + 1);

  logic [2*W-1:0] dbl_shift;
  logic [W-1:0]   rotated;
  logic [CNT_W-1:0] ffs_idx;
  logic [CNT_W-1:0] pop_cnt;

  // Left rotate: shift a doubled copy, keep the upper half
  always_comb begin
    dbl_shift = {b, b} << rot;
    rotated   = dbl_shift[2*W-1:W];
  end

  // R8: per-lane merge, cleared lanes read zero
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign fld_res[8*g +: 8] = bmask[g] ? rotated[8*g +: 8] : 8'h00;
  end

  // R9: scan from the top so the lowest set bit wins
  always_comb begin
    ffs_idx  = '0;
    ffs_none = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (b[i]) begin
        ffs_idx  = CNT_W'(i);
        ffs_none = 1'b0;
      end
    end
  end

  // R10
  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < W; i++) begin
      pop_cnt = pop_cnt + CNT_W'(b[i]);
    end
  end

  assign ffs_res = {{(W-CNT_W){1'b0}}, ffs_idx};
  assign pop_res = {{(W-CNT_W){1'b0}}, pop_cnt};

endmodule

// File: rtl/pkt_alu.sv
module pkt_alu #(
  parameter int W  = 32,
  parameter int NB = W / 8,
  parameter int RW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [NB-1:0] in_bmask,
  input  logic [RW-1:0] in_rot,
  input  logic          in_setcc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_nobit,
  output logic [3:0]    cc_o
);
  import pkt_alu_pkg::*;

  cc_t          cc_q;
  cc_t          cc_nxt;
  logic [W-1:0] res_nxt;
  logic         nobit_nxt;
  logic         cc_upd;
  logic         v_nxt;
  logic         c_nxt;
  logic         take;

  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;
  logic [W-1:0] logic_res;
  logic [W-1:0] fld_res;
  logic [W-1:0] ffs_res;
  logic         ffs_none;
  logic [W-1:0] pop_res;

  pkt_alu_arith #(.W(W)) u_arith (
    .op        (in_op),
    .a         (in_a),
    .b         (in_b),
    .cin       (cc_q.c),
    .sum       (sum),
    .cout      (cout),
    .ovf       (ovf),
    .logic_res (logic_res)
  );

  pkt_alu_bits #(.W(W), .NB(NB), .RW(RW)) u_bits (
    .b        (in_b),
    .bmask    (in_bmask),
    .rot      (in_rot),
    .fld_res  (fld_res),
    .ffs_res  (ffs_res),
    .ffs_none (ffs_none),
    .pop_res  (pop_res)
  );

  // R12: one-deep output, refilled in the cycle it drains
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  // Result select and flag candidate
  always_comb begin
    res_nxt   = '0;
    nobit_nxt = 1'b0;
    cc_upd    = 1'b1;
    v_nxt     = 1'b0;
    c_nxt     = 1'b0;
    case (in_op)
      OP_MOVB: res_nxt = in_b;
      OP_ADD, OP_ADDC, OP_ADD8, OP_SUB: begin
        res_nxt = sum;
        v_nxt   = ovf;
        c_nxt   = cout;
      end
      OP_AND, OP_ANDN, OP_OR, OP_XOR: res_nxt = logic_res;
      OP_FLD: begin
        res_nxt = fld_res;
        cc_upd  = 1'b0;
      end
      OP_FFS: begin
        res_nxt   = ffs_res;
        nobit_nxt = ffs_none;
      end
      OP_POPC: res_nxt = pop_res;
      default: cc_upd = 1'b0;
    endcase

    cc_nxt = cc_q;
    if (cc_upd && in_setcc) begin
      cc_nxt.n = res_nxt[W-1];
      cc_nxt.z = (res_nxt == '0);
      cc_nxt.v = v_nxt;
      cc_nxt.c = c_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_nobit <= 1'b0;
      cc_q      <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= res_nxt;
      out_nobit <= nobit_nxt;
      cc_q      <= cc_nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign cc_o = cc_q;

endmodule

// File: rtl/pkt_alu_chk.sv
module pkt_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic [W-1:0] in_b,
  input logic         in_setcc,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_nobit,
  input logic [3:0]   cc_o
);
  logic took;
  assign took = in_valid && in_ready;

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(cc_o)));

  // R12
  idle_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable(cc_o));

  // R11
  nowrite_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !in_setcc) |=> $stable(cc_o));

  // R8
  fld_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_op == 4'd9) |=> $stable(cc_o));

  // R2
  movb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_op == 4'd0 && in_setcc) |=> (cc_o[1:0] == 2'b00 && out_data == $past(in_b)));

  // R9
  nobit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_op == 4'd10 && in_b == '0) |=> (out_nobit && out_data == '0));

  // R10
  popc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_op == 4'd11) |=> (out_data <= W'(W)));

endmodule

bind pkt_alu pkt_alu_chk #(.W(W)) i_pkt_alu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_b      (in_b),
  .in_setcc  (in_setcc),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_nobit (out_nobit),
  .cc_o      (cc_o)
);

// File: tb/test_pkt_alu.sv
module test_pkt_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [3:0]  in_bmask = '0;
  logic [4:0]  in_rot = '0;
  logic        in_setcc = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_nobit;
  logic [3:0]  cc_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] exp_cc = '0;

  always #4 clk = ~clk;

  pkt_alu i_pkt_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_bmask(in_bmask),
    .in_rot(in_rot), .in_setcc(in_setcc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_nobit(out_nobit),
    .cc_o(cc_o)
  );

  // Expected {nobit, cc, result} from the requirements
  function automatic logic [36:0] ref_model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                            logic [3:0] mask, logic [4:0] rot, logic we,
                                            logic [3:0] cc);
    logic [32:0] s;
    logic [31:0] r, bb, rv;
    logic v, c, nob, upd;
    logic [3:0] ncc;
    r = '0; v = 0; c = 0; nob = 0; upd = 1; s = '0;
    rv = (rot == 0) ? b : ((b << rot) | (b >> (32 - int'(rot))));
    bb = (op == 4'd3) ? {24'h0, b[7:0]} : b;
    case (op)
      4'd0: r = b;
      4'd1, 4'd2, 4'd3: begin
        s = {1'b0, a} + {1'b0, bb} + ((op == 4'd2) ? {32'h0, cc[0]} : 33'h0);
        r = s[31:0]; c = s[32];
        v = (a[31] == bb[31]) && (r[31] != a[31]);
      end
      4'd4: begin
        r = a - b; c = (a >= b);
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'd5: r = a & b;
      4'd6: r = a & ~b;
      4'd7: r = a | b;
      4'd8: r = a ^ b;
      4'd9: begin
        upd = 0;
        for (int k = 0; k < 4; k++) if (mask[k]) r[8*k +: 8] = rv[8*k +: 8];
      end
      4'd10: begin
        for (int k = 31; k >= 0; k--) if (b[k]) r = k;
        nob = (b == 0);
      end
      4'd11: r = $countones(b);
      default: upd = 0;
    endcase
    ncc = (upd && we) ? {r[31], (r == 0), v, c} : cc;
    return {nob, ncc, r};
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5, 4'd6, 4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the result is due
  task automatic run_op(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [3:0] mask,
                        logic [4:0] rot, logic we, string req);
    logic [36:0] e;
    e = ref_model(op, a, b, mask, rot, we, exp_cc);
    in_op = op; in_a = a; in_b = b; in_bmask = mask; in_rot = rot; in_setcc = we;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && {out_nobit, cc_o, out_data} == e, req,
          {26'h0, out_valid, out_nobit, cc_o, out_data}, {26'h0, 1'b1, e});
    exp_cc = e[35:32];
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic [3:0]  held_cc;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!out_valid && out_data == 0 && !out_nobit && cc_o == 0 && in_ready, "R1",
          {27'h0, out_valid, out_nobit, cc_o, out_data[0]}, 64'h0);

    // R2: move sets N, then Z
    run_op(4'd0, 32'h0, 32'h8000_0000, 4'h0, 5'd0, 1'b1, "R2 move negative");
    run_op(4'd0, 32'h0, 32'h0, 4'h0, 5'd0, 1'b1, "R2 move zero");
    // R3: carry out and overflow
    run_op(4'd1, 32'hFFFF_FFFF, 32'h1, 4'h0, 5'd0, 1'b1, "R3 add carry");
    run_op(4'd1, 32'h7FFF_FFFF, 32'h1, 4'h0, 5'd0, 1'b1, "R3 add overflow");
    // R4: 64-bit chain
    run_op(4'd1, 32'hFFFF_FFF0, 32'h0000_0020, 4'h0, 5'd0, 1'b1, "R4 low word");
    run_op(4'd2, 32'h0000_0001, 32'h0000_0002, 4'h0, 5'd0, 1'b1, "R4 high word");
    // R5
    run_op(4'd3, 32'h0000_0010, 32'hFFFF_FF05, 4'h0, 5'd0, 1'b1, "R5 byte add");
    // R6
    run_op(4'd4, 32'd5, 32'd5, 4'h0, 5'd0, 1'b1, "R6 sub equal");
    run_op(4'd4, 32'd3, 32'd5, 4'h0, 5'd0, 1'b1, "R6 sub borrow");
    run_op(4'd4, 32'h8000_0000, 32'd1, 4'h0, 5'd0, 1'b1, "R6 sub overflow");
    // R7
    run_op(4'd6, 32'hF0F0_FFFF, 32'h00F0_000F, 4'h0, 5'd0, 1'b1, "R7 and-not");
    run_op(4'd8, 32'h1234_5678, 32'h1234_5678, 4'h0, 5'd0, 1'b1, "R7 xor zero");
    // R8: flags stay even with updating enabled
    run_op(4'd1, 32'hFFFF_FFFF, 32'h1, 4'h0, 5'd0, 1'b1, "R3 set flags");
    run_op(4'd9, 32'h0, 32'h1234_5678, 4'b0101, 5'd8, 1'b1, "R8 field load");
    check(out_data == 32'h0056_0012, "R8 merge value", {32'h0, out_data}, 64'h0056_0012);
    run_op(4'd9, 32'h0, 32'hA5A5_0000, 4'b1111, 5'd0, 1'b1, "R8 no rotate");
    // R9
    run_op(4'd10, 32'h0, 32'h0000_0C00, 4'h0, 5'd0, 1'b1, "R9 ffs");
    run_op(4'd10, 32'h0, 32'h0, 4'h0, 5'd0, 1'b1, "R9 ffs zero");
    run_op(4'd10, 32'h0, 32'h8000_0000, 4'h0, 5'd0, 1'b1, "R9 ffs top");
    // R10
    run_op(4'd11, 32'h0, 32'hFFFF_FFFF, 4'h0, 5'd0, 1'b1, "R10 popcount full");
    run_op(4'd11, 32'h0, 32'h0000_0301, 4'h0, 5'd0, 1'b1, "R10 popcount");
    // R11
    run_op(4'd4, 32'd3, 32'd5, 4'h0, 5'd0, 1'b0, "R11 no update");
    run_op(4'd15, 32'h1, 32'h1, 4'hF, 5'd3, 1'b1, "R11 unused opcode");

    // R12: stall holds output and refuses the next operation
    @(negedge clk);
    out_ready = 1'b0;
    run_op(4'd0, 32'h0, 32'h0000_0055, 4'h0, 5'd0, 1'b1, "R12 first");
    held = out_data; held_cc = cc_o;
    in_op = 4'd1; in_a = 32'h1; in_b = 32'h1; in_setcc = 1'b1; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!in_ready && out_valid && out_data == held && cc_o == held_cc, "R12 stall",
            {27'h0, in_ready, cc_o, out_data}, {27'h0, 1'b0, held_cc, held});
    end
    out_ready = 1'b1;
    #1 check(in_ready, "R12 ready on drain", {63'h0, in_ready}, 64'h1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_data == 32'd2 && cc_o == 4'b0000, "R12 second",
          {27'h0, out_valid, cc_o, out_data}, {27'h0, 1'b1, 4'b0000, 32'd2});
    exp_cc = cc_o;

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      a = $urandom();
      b = ($urandom_range(0, 9) == 0) ? 32'h0 : $urandom();
      if ($urandom_range(0, 4) == 0) b = b & 32'h0000_00FF;
      run_op(op, a, b, 4'($urandom_range(0, 15)), 5'($urandom_range(0, 31)),
             1'($urandom_range(0, 3) != 0), tag_of(op));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule